// File: doc/BRIEF.md
# USB Port Low-Power Entry and Exit Sequencer

This block steps a USB port and its transceiver into low-power suspend and back out again. It drives the control bits that a port controller and an analog transceiver expect, one per cycle in a fixed order, and it waits on their status inputs where the timing is not fixed. Host mode and device mode enter suspend along different paths. In host mode the block first turns off the high-speed disconnect detector and asks the port to suspend. In device mode it waits for the controller's suspend interrupt. Both paths then stop the transceiver clock, power the transceiver down and gate its clock.

Once the port is in low power, the wakeup interrupt is enabled. In host mode a timer counts microsecond ticks while the bus stays idle. After 300 of them it enables wake-on-disconnect, which avoids a false disconnect wakeup. There are two ways out. A bus wakeup event releases all power controls at once and then drops the interrupt enable. A CPU resume request releases the controls, drives force-resume until the port reports that resume signalling is finished, and only then turns the disconnect detector back on. A suspend request that arrives during an exit is kept and acted on when the block is active again.

Top module: `usb_lp_seq`

## Requirements
- R1: After reset the block is active. In the active state every output is low except `discon_det_en`, which equals `mode_host` (1 = host, 0 = device).
- R2: In host mode, a `susp_req` seen while active drops `discon_det_en` in the next cycle. In the cycle after that, `port_suspend` rises and the block holds there, with no other output high, for as long as `port_susp_ack` stays low.
- R3: In the cycle after `port_susp_ack` is sampled high, `phy_clk_off` rises. `pwr_down` joins it one cycle later and `clk_gate` one cycle after that. `port_suspend` stays high throughout.
- R4: In device mode, a `susp_req` while active leads to a wait in which all outputs are low until `dev_susp_irq` is sampled. Then `phy_clk_off`, `pwr_down` and `clk_gate` rise on three successive cycles. `port_suspend` and `discon_det_en` are never raised on this path.
- R5: `wake_irq_en` rises only in the cycle after `clk_gate` has risen, which is the low-power state. There all three power controls are high, and in host mode `port_suspend` is high as well.
- R6: In host low power, `wake_discon_en` rises in the cycle after the 300th `us_tick` that is sampled while `bus_idle` is continuously high. Further ticks keep it high. It never rises in device mode.
- R7: A cycle with `bus_idle` low clears the idle count and drops `wake_discon_en`. Another full 300 ticks are then needed.
- R8: `wake_evt` in low power clears `port_suspend`, `phy_clk_off`, `pwr_down`, `clk_gate` and `wake_discon_en` in the next cycle, with `wake_irq_en` held high for that one cycle. The block is active one cycle later. `wake_evt` takes priority over `cpu_resume` when both are high.
- R9: `cpu_resume` in low power clears every output in the next cycle. `force_resume` is high from the cycle after that until `resume_done` is sampled high. One further cycle follows with all outputs low, and then the block is active, with `discon_det_en` back on in host mode.
- R10: A `susp_req` sampled during either exit path is held and starts a new entry one cycle after the block becomes active. A `susp_req` sampled during entry or in low power has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_host | input | 1 | 1 selects host entry path, 0 device path |
| susp_req | input | 1 | Request to enter low-power suspend |
| port_susp_ack | input | 1 | Port suspend status from the port controller |
| dev_susp_irq | input | 1 | Device-mode suspend interrupt |
| bus_idle | input | 1 | Bus is in the idle (J) state |
| wake_evt | input | 1 | Wakeup event detected on the bus |
| cpu_resume | input | 1 | CPU request to leave low power |
| resume_done | input | 1 | Port has finished forced resume signalling |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| discon_det_en | output | 1 | High-speed disconnect detector enable |
| port_suspend | output | 1 | Port suspend request |
| phy_clk_off | output | 1 | Transceiver clock-disable request |
| pwr_down | output | 1 | Transceiver power-down controls |
| clk_gate | output | 1 | Transceiver clock gate |
| wake_discon_en | output | 1 | Wake-on-disconnect enable |
| force_resume | output | 1 | Force resume on the port |
| wake_irq_en | output | 1 | Wakeup interrupt enable |

## Verification
The assertions assume that the responders behave like a real port. `port_susp_ack` is raised only after `port_suspend`, `dev_susp_irq` arrives only while the block waits for it, and `resume_done` is pulsed only while `force_resume` is high. The bench drives these inputs only at those points of each entry and exit, with random delays. It leaves `wake_evt` and `cpu_resume` low except in the low-power state, and keeps `us_tick` a single-cycle pulse.

// File: rtl/usb_lp_pkg.sv
package usb_lp_pkg;

    typedef enum logic [3:0] {
        ST_ACTIVE,
        ST_H_DETOFF,
        ST_H_SUSP,
        ST_H_PHCD,
        ST_H_PWD,
        ST_H_GATE,
        ST_D_WAIT,
        ST_D_PHCD,
        ST_D_PWD,
        ST_D_GATE,
        ST_LOWPWR,
        ST_WK_CLR,
        ST_CPU_CLR,
        ST_FRES,
        ST_REEN
    } lp_state_e;

    typedef struct packed {
        lp_state_e st;
        logic      host;
        logic      pend;
    } lp_regs_t;

    typedef struct packed {
        logic det_en;
        logic port_susp;
        logic phcd;
        logic pwr_dn;
        logic clk_gate;
        logic wake_dis;
        logic force_res;
        logic wake_ie;
    } lp_ctl_t;

endpackage

// File: rtl/usb_lp_idle_timer.sv
module usb_lp_idle_timer #(
    parameter int IDLE_US = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic idle,
    input  logic tick,
    output logic done
);
    localparam int CNT_W = $clog2(IDLE_US + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_US);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en || !idle) begin
            cnt_d = '0;
        end else if (tick && cnt_q != LIMIT) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == LIMIT);

    // R6: the count never passes the limit
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);

    // R7: loss of idle restarts the window
    assert_idle_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle) |=> !done);

endmodule

// File: rtl/usb_lp_fsm.sv
module usb_lp_fsm
    import usb_lp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    mode_host,
    input  logic    susp_req,
    input  logic    port_susp_ack,
    input  logic    dev_susp_irq,
    input  logic    wake_evt,
    input  logic    cpu_resume,
    input  logic    resume_done,
    input  logic    idle_done,
    output logic    timer_en,
    output lp_ctl_t ctl
);
    lp_regs_t r_d, r_q;
    logic     in_exit;

    assign in_exit = (r_q.st == ST_WK_CLR) || (r_q.st == ST_CPU_CLR) ||
                     (r_q.st == ST_FRES)   || (r_q.st == ST_REEN);

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_ACTIVE: begin
                if (susp_req || r_q.pend) begin
                    r_d.pend = 1'b0;
                    r_d.host = mode_host;
                    r_d.st   = mode_host ? ST_H_DETOFF : ST_D_WAIT;
                end
            end
            ST_H_DETOFF: r_d.st = ST_H_SUSP;
            ST_H_SUSP:   if (port_susp_ack) r_d.st = ST_H_PHCD;
            ST_H_PHCD:   r_d.st = ST_H_PWD;
            ST_H_PWD:    r_d.st = ST_H_GATE;
            ST_H_GATE:   r_d.st = ST_LOWPWR;
            ST_D_WAIT:   if (dev_susp_irq) r_d.st = ST_D_PHCD;
            ST_D_PHCD:   r_d.st = ST_D_PWD;
            ST_D_PWD:    r_d.st = ST_D_GATE;
            ST_D_GATE:   r_d.st = ST_LOWPWR;
            ST_LOWPWR: begin
                if (wake_evt)        r_d.st = ST_WK_CLR;
                else if (cpu_resume) r_d.st = ST_CPU_CLR;
            end
            ST_WK_CLR:   r_d.st = ST_ACTIVE;
            ST_CPU_CLR:  r_d.st = ST_FRES;
            ST_FRES:     if (resume_done) r_d.st = ST_REEN;
            ST_REEN:     r_d.st = ST_ACTIVE;
            default:     r_d.st = ST_ACTIVE;
        endcase
        if (in_exit && susp_req) begin
            r_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_ACTIVE;
            r_q.host <= 1'b0;
            r_q.pend <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        ctl           = '0;
        ctl.det_en    = (r_q.st == ST_ACTIVE) && mode_host;
        ctl.port_susp = (r_q.st == ST_H_SUSP) || (r_q.st == ST_H_PHCD) ||
                        (r_q.st == ST_H_PWD)  || (r_q.st == ST_H_GATE) ||
                        ((r_q.st == ST_LOWPWR) && r_q.host);
        ctl.phcd      = (r_q.st == ST_H_PHCD) || (r_q.st == ST_H_PWD) ||
                        (r_q.st == ST_H_GATE) || (r_q.st == ST_D_PHCD) ||
                        (r_q.st == ST_D_PWD)  || (r_q.st == ST_D_GATE) ||
                        (r_q.st == ST_LOWPWR);
        ctl.pwr_dn    = (r_q.st == ST_H_PWD)  || (r_q.st == ST_H_GATE) ||
                        (r_q.st == ST_D_PWD)  || (r_q.st == ST_D_GATE) ||
                        (r_q.st == ST_LOWPWR);
        ctl.clk_gate  = (r_q.st == ST_H_GATE) || (r_q.st == ST_D_GATE) ||
                        (r_q.st == ST_LOWPWR);
        ctl.wake_ie   = (r_q.st == ST_LOWPWR) || (r_q.st == ST_WK_CLR);
        ctl.force_res = (r_q.st == ST_FRES);
        ctl.wake_dis  = (r_q.st == ST_LOWPWR) && r_q.host && idle_done;
    end

    assign timer_en = (r_q.st == ST_LOWPWR) && r_q.host;

    // R2: port suspend is only requested after the detector was turned off
    assert_susp_after_detoff_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl.port_susp) |-> $past(!ctl.det_en));

    // R3: in host mode the clock-disable waits for the port suspend status
    assert_phcd_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctl.phcd) && r_q.host) |-> $past(port_susp_ack));

    // R4: in device mode the clock-disable waits for the suspend interrupt
    assert_phcd_after_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctl.phcd) && !r_q.host) |-> $past(dev_susp_irq));

    // R5: wakeup interrupt enabled only once the clock was already gated
    assert_wie_after_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl.wake_ie) |-> (ctl.clk_gate && $past(ctl.clk_gate)));

    // R8: power controls release only on a wakeup or a CPU resume
    assert_release_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl.phcd) |-> $past(wake_evt || cpu_resume));

    // R9: force-resume drops only after the port reports completion
    assert_fres_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl.force_res) |-> $past(resume_done));

endmodule

// File: rtl/usb_lp_seq.sv
module usb_lp_seq
    import usb_lp_pkg::*;
#(
    parameter int IDLE_US = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_host,
    input  logic susp_req,
    input  logic port_susp_ack,
    input  logic dev_susp_irq,
    input  logic bus_idle,
    input  logic wake_evt,
    input  logic cpu_resume,
    input  logic resume_done,
    input  logic us_tick,
    output logic discon_det_en,
    output logic port_suspend,
    output logic phy_clk_off,
    output logic pwr_down,
    output logic clk_gate,
    output logic wake_discon_en,
    output logic force_resume,
    output logic wake_irq_en
);
    lp_ctl_t ctl;
    logic    timer_en;
    logic    idle_done;

    usb_lp_idle_timer #(.IDLE_US(IDLE_US)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (timer_en),
        .idle  (bus_idle),
        .tick  (us_tick),
        .done  (idle_done)
    );

    usb_lp_fsm i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_host     (mode_host),
        .susp_req      (susp_req),
        .port_susp_ack (port_susp_ack),
        .dev_susp_irq  (dev_susp_irq),
        .wake_evt      (wake_evt),
        .cpu_resume    (cpu_resume),
        .resume_done   (resume_done),
        .idle_done     (idle_done),
        .timer_en      (timer_en),
        .ctl           (ctl)
    );

    assign discon_det_en  = ctl.det_en;
    assign port_suspend   = ctl.port_susp;
    assign phy_clk_off    = ctl.phcd;
    assign pwr_down       = ctl.pwr_dn;
    assign clk_gate       = ctl.clk_gate;
    assign wake_discon_en = ctl.wake_dis;
    assign force_resume   = ctl.force_res;
    assign wake_irq_en    = ctl.wake_ie;

    // R6: wake-on-disconnect only in host low power with the clock gated
    assert_wkd_host_lp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_discon_en |-> (clk_gate && port_suspend && wake_irq_en));

endmodule

// File: tb/test_usb_lp_seq.sv
module test_usb_lp_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_host = 1'b1, susp_req = 1'b0, port_susp_ack = 1'b0, dev_susp_irq = 1'b0;
    logic bus_idle = 1'b0, wake_evt = 1'b0, cpu_resume = 1'b0, resume_done = 1'b0, us_tick = 1'b0;
    logic discon_det_en, port_suspend, phy_clk_off, pwr_down, clk_gate;
    logic wake_discon_en, force_resume, wake_irq_en;
    int n_chk = 0;
    int n_bad = 0;
    bit over = 1'b0;

    always #5 clk = ~clk;

    usb_lp_seq i_usb_lp_seq (
        .clk(clk), .rst_n(rst_n), .mode_host(mode_host), .susp_req(susp_req),
        .port_susp_ack(port_susp_ack), .dev_susp_irq(dev_susp_irq), .bus_idle(bus_idle),
        .wake_evt(wake_evt), .cpu_resume(cpu_resume), .resume_done(resume_done),
        .us_tick(us_tick), .discon_det_en(discon_det_en), .port_suspend(port_suspend),
        .phy_clk_off(phy_clk_off), .pwr_down(pwr_down), .clk_gate(clk_gate),
        .wake_discon_en(wake_discon_en), .force_resume(force_resume), .wake_irq_en(wake_irq_en)
    );

    // order: det, susp, phcd, pwd, gate, wkd, fres, wie
    function automatic logic [7:0] mk(bit det, bit sus, bit phcd, bit pwd, bit gate,
                                      bit wkd, bit fres, bit wie);
        return {det, sus, phcd, pwd, gate, wkd, fres, wie};
    endfunction

    function automatic logic [7:0] lp_host(bit wkd);
        return mk(0, 1, 1, 1, 1, wkd, 0, 1);
    endfunction

    function automatic logic [7:0] active(bit host);
        return mk(host, 0, 0, 0, 0, 0, 0, 0);
    endfunction

    task automatic finish_up();
        if (!over) begin
            over = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(string req, logic [7:0] exp);
        logic [7:0] got;
        got = {discon_det_en, port_suspend, phy_clk_off, pwr_down, clk_gate,
               wake_discon_en, force_resume, wake_irq_en};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            us_tick = 1'b1;
            step();
            us_tick = 1'b0;
        end
    endtask

    task automatic enter_host(int dly);
        susp_req = 1'b1; step(); susp_req = 1'b0;
        check("R2 detector off", mk(0,0,0,0,0,0,0,0));
        step();
        check("R2 port suspend", mk(0,1,0,0,0,0,0,0));
        for (int i = 0; i < dly; i++) begin
            step();
            check("R2 wait ack", mk(0,1,0,0,0,0,0,0));
        end
        port_susp_ack = 1'b1;
        step();
        check("R3 phcd", mk(0,1,1,0,0,0,0,0));
        step();
        check("R3 pwd", mk(0,1,1,1,0,0,0,0));
        step();
        check("R3 gate", mk(0,1,1,1,1,0,0,0));
        step();
        check("R5 low power host", lp_host(0));
    endtask

    task automatic enter_dev(int dly);
        susp_req = 1'b1; step(); susp_req = 1'b0;
        check("R4 wait irq", mk(0,0,0,0,0,0,0,0));
        for (int i = 0; i < dly; i++) begin
            step();
            check("R4 wait irq", mk(0,0,0,0,0,0,0,0));
        end
        dev_susp_irq = 1'b1; step(); dev_susp_irq = 1'b0;
        check("R4 phcd", mk(0,0,1,0,0,0,0,0));
        step();
        check("R4 pwd", mk(0,0,1,1,0,0,0,0));
        step();
        check("R4 gate", mk(0,0,1,1,1,0,0,0));
        step();
        check("R5 low power dev", mk(0,0,1,1,1,0,0,1));
    endtask

    task automatic exit_wake(bit host);
        port_susp_ack = 1'b0;
        wake_evt = 1'b1; step(); wake_evt = 1'b0;
        check("R8 wake clear", mk(0,0,0,0,0,0,0,1));
        step();
        check("R8 back active", active(host));
    endtask

    task automatic exit_cpu(bit host, int dly);
        port_susp_ack = 1'b0;
        cpu_resume = 1'b1; step(); cpu_resume = 1'b0;
        check("R9 release", mk(0,0,0,0,0,0,0,0));
        step();
        check("R9 force resume", mk(0,0,0,0,0,0,1,0));
        for (int i = 0; i < dly; i++) begin
            step();
            check("R9 force resume held", mk(0,0,0,0,0,0,1,0));
        end
        resume_done = 1'b1; step(); resume_done = 1'b0;
        check("R9 fres dropped", mk(0,0,0,0,0,0,0,0));
        step();
        check("R9 detector back", active(host));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        step();
        check("R1 reset host", active(1));
        mode_host = 1'b0; #1;
        check("R1 reset device", active(0));
        mode_host = 1'b1; #1;

        // host entry, idle window, restart
        enter_host(3);
        bus_idle = 1'b1;
        ticks(299);
        check("R6 before 300", lp_host(0));
        ticks(1);
        check("R6 at 300", lp_host(1));
        ticks(5);
        check("R6 saturate", lp_host(1));
        bus_idle = 1'b0; step();
        check("R7 idle drop", lp_host(0));
        bus_idle = 1'b1;
        ticks(150);
        bus_idle = 1'b0; step(); bus_idle = 1'b1;
        ticks(299);
        check("R7 restart 299", lp_host(0));
        ticks(1);
        check("R7 restart 300", lp_host(1));
        bus_idle = 1'b0;
        step();

        // request in low power is ignored
        susp_req = 1'b1; step(); susp_req = 1'b0;
        check("R10 ignored in lp", lp_host(0));
        exit_wake(1);
        step();
        check("R10 no stray entry", active(1));

        // wake priority over cpu
        enter_host(0);
        wake_evt = 1'b1; cpu_resume = 1'b1; step();
        wake_evt = 1'b0; cpu_resume = 1'b0;
        check("R8 wake wins", mk(0,0,0,0,0,0,0,1));
        step();
        check("R8 active after", active(1));

        // device path, no wake-on-disconnect
        mode_host = 1'b0; #1;
        enter_dev(2);
        bus_idle = 1'b1;
        ticks(310);
        check("R6 none in device", mk(0,0,1,1,1,0,0,1));
        bus_idle = 1'b0;
        exit_cpu(0, 3);

        // pending request during cpu exit
        mode_host = 1'b1; #1;
        enter_host(1);
        port_susp_ack = 1'b0;
        cpu_resume = 1'b1; step(); cpu_resume = 1'b0;
        check("R9 release", mk(0,0,0,0,0,0,0,0));
        step();
        check("R9 force resume", mk(0,0,0,0,0,0,1,0));
        susp_req = 1'b1; step(); susp_req = 1'b0;
        check("R10 held in exit", mk(0,0,0,0,0,0,1,0));
        resume_done = 1'b1; step(); resume_done = 1'b0;
        check("R9 fres dropped", mk(0,0,0,0,0,0,0,0));
        step();
        check("R10 active first", active(1));
        step();
        check("R10 pending entry", mk(0,0,0,0,0,0,0,0));
        step();
        check("R10 pending suspend", mk(0,1,0,0,0,0,0,0));
        port_susp_ack = 1'b1;
        repeat (4) step();
        check("R10 pending lp", lp_host(0));
        exit_wake(1);

        // pending request during wake clear, device mode
        mode_host = 1'b0; #1;
        enter_dev(0);
        wake_evt = 1'b1; step(); wake_evt = 1'b0;
        check("R8 wake clear dev", mk(0,0,0,0,0,0,0,1));
        susp_req = 1'b1; step(); susp_req = 1'b0;
        check("R10 active dev", active(0));
        step();
        dev_susp_irq = 1'b1; step(); dev_susp_irq = 1'b0;
        check("R10 pending dev entry", mk(0,0,1,0,0,0,0,0));
        repeat (3) step();
        exit_wake(0);

        // random mix
        for (int it = 0; it < 24; it++) begin
            bit h;
            int n;
            h = 1'($urandom % 2);
            mode_host = h; #1;
            check("R1 active", active(h));
            if (h) enter_host(int'($urandom % 6));
            else   enter_dev(int'($urandom % 6));
            if (h && ($urandom % 2 == 1)) begin
                n = int'($urandom % 300);
                bus_idle = 1'b1;
                ticks(n);
                check("R6 partial window", lp_host(0));
                bus_idle = 1'b0;
                step();
            end
            if ($urandom % 2 == 1) exit_wake(h);
            else exit_cpu(h, int'($urandom % 5));
        end

        finish_up();
    end
endmodule